// File: doc/BRIEF.md
# Audio clock regeneration lock controller

This block is the control side of an audio clock regenerator. It runs on the regenerated audio master clock, which is 128 times the audio sampling rate. It receives N/CTS pairs taken from audio clock regeneration packets, each with a valid strobe. It also receives the TMDS PLL lock status and raw link events. From these it decides when a fresh N/CTS pair is loaded into the numeric DPLL core, and it reports whether the regenerator is locked.

A coast request tells the DPLL core to hold its present frequency, so the master clock stays steady while the link misbehaves. The request is built from six link events, each of which can be masked on its own. One of them fires when CTS jumps by more than a programmable threshold. A small register interface holds the coast masks and the threshold. It also has a self-clearing bit that forces a reload of the latest pair, and a read-only lock status bit.

The lock qualifier is a three-state machine with these states:
- `LK_IDLE`: not locked.
- `LK_QUAL`: both lock conditions seen for one cycle.
- `LK_LOCKED`: locked.

It has these transitions:
- `LK_IDLE` goes to `LK_QUAL` when both conditions hold.
- `LK_QUAL` goes to `LK_LOCKED` while they still hold.
- `LK_QUAL` falls back to `LK_IDLE` otherwise.
- `LK_LOCKED` returns to `LK_IDLE` when the TMDS PLL loses lock.

Top module: `acr_lock_ctrl`

## Requirements
- R1: After reset, `audio_locked`, `load_strobe` and `coast_req` are 0, and every register reads 0.
- R2: With `tmds_pll_locked` high, a good packet arriving in cycle t raises `audio_locked` in cycle t+2. A good packet is `acr_valid` high with both N and CTS non-zero.
- R3: A packet with N = 0 or CTS = 0 is ignored. It does not count toward lock, it does not cause a load, and it does not end a coast.
- R4: When `tmds_pll_locked` is low, `audio_locked` is 0 in the next cycle. Lock then needs the PLL locked again plus a new good packet.
- R5: A good packet whose pair differs from the loaded pair, arriving in cycle t outside coast, gives a one-cycle `load_strobe` in cycle t+1, with `load_n`/`load_cts` carrying that pair. A packet equal to the loaded pair gives no strobe.
- R6: Address 0 bit 0 is the force bit. Writing 1 in cycle w gives a `load_strobe` of the latest pair in cycle w+2 (outside coast). The bit clears itself after one cycle and always reads 0. Writing 0 does nothing.
- R7: Address 1 holds the coast mask. Each bit enables one event:
  - bit 6: irregular TMDS clock (`ev_clk_irregular`)
  - bit 5: TMDS PLL unlocked
  - bit 3: CTS jump
  - bit 2: N change against the previous good packet
  - bit 1: port change (`ev_port_change`)
  - bit 0: no TMDS clock (`ev_no_clk`)
  
  Bits 7 and 4 always read 0. An unmasked event never requests coast.
- R8: Address 2 holds the 6-bit CTS threshold. A CTS jump is an event only when |new CTS − previous good CTS| is strictly greater than the threshold.
- R9: `coast_req` is high in any cycle with a masked event. It stays high until a good packet with no masked event arrives, and it drops in the cycle after that packet.
- R10: No `load_strobe` follows a cycle in which `coast_req` is high. A reload held back by coast is issued in the cycle after the first cycle with `coast_req` low.
- R11: Address 3 bit 0 reads the lock status. Writes to address 3 are ignored, and reads of address 1 and 2 return the written mask and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock (128 × fs) |
| rst_n | input | 1 | Asynchronous active-low reset |
| acr_valid | input | 1 | New N/CTS pair present this cycle |
| acr_n | input | 20 | Received N value |
| acr_cts | input | 20 | Received CTS value |
| tmds_pll_locked | input | 1 | TMDS PLL lock status |
| ev_clk_irregular | input | 1 | Raw flag: irregular or missing TMDS clock pulses |
| ev_no_clk | input | 1 | Raw flag: no TMDS clock on the active port |
| ev_port_change | input | 1 | Raw flag: active port changed |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| load_strobe | output | 1 | One-cycle load of a pair into the DPLL core |
| load_n | output | 20 | N value loaded into the DPLL core |
| load_cts | output | 20 | CTS value loaded into the DPLL core |
| coast_req | output | 1 | Hold the DPLL frequency |
| audio_locked | output | 1 | Lock status |

## Verification
The assertions assume that `tmds_pll_locked`, the raw event flags and the packet strobe are synchronous to the master clock and stable around its rising edge. They also assume that a mask write never arrives in the same cycle as a packet whose release they check. The bench drives every input on the falling edge and issues register writes only in cycles without packets. A behavioural model in the bench tracks the expected lock count, pending reload, latched coast and register contents, and the bench compares every output against it on each clock.

// File: rtl/acr_pkg.sv
package acr_pkg;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_QUAL   = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_e;

    // Coast mask bit positions
    localparam int MB_NO_CLK    = 0;
    localparam int MB_PORT      = 1;
    localparam int MB_N_CHG     = 2;
    localparam int MB_CTS_JUMP  = 3;
    localparam int MB_PLL_LOSS  = 5;
    localparam int MB_CLK_IRREG = 6;

    localparam logic [7:0] MASK_IMPL = 8'h6F;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_MASK = 2'd1;
    localparam logic [1:0] RA_THR  = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

endpackage

// File: rtl/acr_ctrl_regs.sv
module acr_ctrl_regs
    import acr_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          lock_stat,
    output logic          force_pulse,
    output logic [7:0]    coast_mask,
    output logic [TW-1:0] cts_thr,
    output logic [7:0]    rdata
);
    localparam int PAD = 8 - TW;

    logic          force_q;
    logic [7:0]    mask_q;
    logic [TW-1:0] thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            mask_q  <= '0;
            thr_q   <= '0;
        end else begin
            force_q <= wr_en && (addr == RA_CTRL) && wdata[0];
            if (wr_en && addr == RA_MASK) mask_q <= wdata & MASK_IMPL;
            if (wr_en && addr == RA_THR)  thr_q  <= wdata[TW-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = 8'h00;
            RA_MASK: rdata = mask_q;
            RA_THR:  rdata = {{PAD{1'b0}}, thr_q};
            RA_STAT: rdata = {7'b0, lock_stat};
            default: rdata = 8'h00;
        endcase
    end

    assign force_pulse = force_q;
    assign coast_mask  = mask_q;
    assign cts_thr     = thr_q;
endmodule

// File: rtl/acr_coast_eval.sv
module acr_coast_eval
    import acr_pkg::*;
#(
    parameter int NW = 20,
    parameter int CW = 20,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_good,
    input  logic [NW-1:0] pkt_n,
    input  logic [CW-1:0] pkt_cts,
    input  logic          prev_valid,
    input  logic [NW-1:0] prev_n,
    input  logic [CW-1:0] prev_cts,
    input  logic [TW-1:0] cts_thr,
    input  logic [7:0]    mask,
    input  logic          pll_locked,
    input  logic          ev_clk_irregular,
    input  logic          ev_no_clk,
    input  logic          ev_port_change,
    output logic          coast_req
);
    localparam int TPAD = CW - TW;

    logic [CW-1:0] cts_delta;
    logic          n_chg;
    logic          cts_jump;
    logic [7:0]    ev_vec;
    logic          ev_any;
    logic          held_q;

    always_comb begin
        cts_delta = (pkt_cts >= prev_cts) ? (pkt_cts - prev_cts) : (prev_cts - pkt_cts);
        n_chg     = pkt_good && prev_valid && (pkt_n != prev_n);
        cts_jump  = pkt_good && prev_valid && (cts_delta > {{TPAD{1'b0}}, cts_thr});
        ev_vec                = '0;
        ev_vec[MB_NO_CLK]     = ev_no_clk;
        ev_vec[MB_PORT]       = ev_port_change;
        ev_vec[MB_N_CHG]      = n_chg;
        ev_vec[MB_CTS_JUMP]   = cts_jump;
        ev_vec[MB_PLL_LOSS]   = !pll_locked;
        ev_vec[MB_CLK_IRREG]  = ev_clk_irregular;
        ev_any = |(ev_vec & mask);
    end

    // Stretch events until a clean good packet arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= 1'b0;
        else if (ev_any)   held_q <= 1'b1;
        else if (pkt_good) held_q <= 1'b0;
    end

    assign coast_req = ev_any || held_q;
endmodule

// File: rtl/acr_reload.sv
module acr_reload #(
    parameter int NW = 20,
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_good,
    input  logic [NW-1:0] pkt_n,
    input  logic [CW-1:0] pkt_cts,
    input  logic          force_pulse,
    input  logic          coast_req,
    output logic          have_latest,
    output logic [NW-1:0] latest_n,
    output logic [CW-1:0] latest_cts,
    output logic          load_strobe,
    output logic [NW-1:0] load_n,
    output logic [CW-1:0] load_cts
);
    logic          pend_q;
    logic          have_q;
    logic [NW-1:0] lat_n_q,  ld_n_q;
    logic [CW-1:0] lat_c_q,  ld_c_q;
    logic          strobe_q;
    logic          differs;
    logic          want;
    logic [NW-1:0] src_n;
    logic [CW-1:0] src_c;

    always_comb begin
        differs = pkt_good && ((pkt_n != ld_n_q) || (pkt_cts != ld_c_q));
        want    = pend_q || differs || force_pulse;
        src_n   = pkt_good ? pkt_n   : lat_n_q;
        src_c   = pkt_good ? pkt_cts : lat_c_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            have_q   <= 1'b0;
            lat_n_q  <= '0;
            lat_c_q  <= '0;
            ld_n_q   <= '0;
            ld_c_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            if (pkt_good) begin
                lat_n_q <= pkt_n;
                lat_c_q <= pkt_cts;
                have_q  <= 1'b1;
            end
            if (want && !coast_req) begin
                strobe_q <= 1'b1;
                ld_n_q   <= src_n;
                ld_c_q   <= src_c;
                pend_q   <= 1'b0;
            end else begin
                strobe_q <= 1'b0;
                pend_q   <= want;
            end
        end
    end

    assign have_latest = have_q;
    assign latest_n    = lat_n_q;
    assign latest_cts  = lat_c_q;
    assign load_strobe = strobe_q;
    assign load_n      = ld_n_q;
    assign load_cts    = ld_c_q;
endmodule

// File: rtl/acr_lock_fsm.sv
module acr_lock_fsm
    import acr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pll_locked,
    input  logic pkt_good,
    output logic locked
);
    lock_state_e state_q, state_d;
    logic        seen_q;
    logic        both_ok;

    assign both_ok = pll_locked && (seen_q || pkt_good);

    // A good packet must be seen again after every PLL loss
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_q <= 1'b0;
        else if (!pll_locked) seen_q <= 1'b0;
        else if (pkt_good)   seen_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE:   if (both_ok) state_d = LK_QUAL;
            LK_QUAL:   state_d = both_ok ? LK_LOCKED : LK_IDLE;
            LK_LOCKED: if (!pll_locked) state_d = LK_IDLE;
            default:   state_d = LK_IDLE;
        endcase
    end

    always_comb begin
        locked = (state_q == LK_LOCKED);
    end
endmodule

// File: rtl/acr_lock_ctrl.sv
module acr_lock_ctrl #(
    parameter int NW = 20,
    parameter int CW = 20,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acr_valid,
    input  logic [NW-1:0] acr_n,
    input  logic [CW-1:0] acr_cts,
    input  logic          tmds_pll_locked,
    input  logic          ev_clk_irregular,
    input  logic          ev_no_clk,
    input  logic          ev_port_change,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          load_strobe,
    output logic [NW-1:0] load_n,
    output logic [CW-1:0] load_cts,
    output logic          coast_req,
    output logic          audio_locked
);
    logic          pkt_good;
    logic          force_pulse;
    logic [7:0]    coast_mask;
    logic [TW-1:0] cts_thr;
    logic          have_latest;
    logic [NW-1:0] latest_n;
    logic [CW-1:0] latest_cts;

    // Zero N or CTS is outside the valid range
    assign pkt_good = acr_valid && (acr_n != '0) && (acr_cts != '0);

    acr_ctrl_regs #(.TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .lock_stat(audio_locked),
        .force_pulse(force_pulse), .coast_mask(coast_mask),
        .cts_thr(cts_thr), .rdata(reg_rdata)
    );

    acr_coast_eval #(.NW(NW), .CW(CW), .TW(TW)) u_coast (
        .clk(clk), .rst_n(rst_n),
        .pkt_good(pkt_good), .pkt_n(acr_n), .pkt_cts(acr_cts),
        .prev_valid(have_latest), .prev_n(latest_n), .prev_cts(latest_cts),
        .cts_thr(cts_thr), .mask(coast_mask),
        .pll_locked(tmds_pll_locked),
        .ev_clk_irregular(ev_clk_irregular), .ev_no_clk(ev_no_clk),
        .ev_port_change(ev_port_change),
        .coast_req(coast_req)
    );

    acr_reload #(.NW(NW), .CW(CW)) u_reload (
        .clk(clk), .rst_n(rst_n),
        .pkt_good(pkt_good), .pkt_n(acr_n), .pkt_cts(acr_cts),
        .force_pulse(force_pulse), .coast_req(coast_req),
        .have_latest(have_latest), .latest_n(latest_n), .latest_cts(latest_cts),
        .load_strobe(load_strobe), .load_n(load_n), .load_cts(load_cts)
    );

    acr_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n),
        .pll_locked(tmds_pll_locked), .pkt_good(pkt_good),
        .locked(audio_locked)
    );
endmodule

// File: rtl/acr_lock_ctrl_chk.sv
module acr_lock_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tmds_pll_locked,
    input logic acr_valid,
    input logic coast_req,
    input logic load_strobe,
    input logic audio_locked,
    input logic mask_pll
);
    // R10: nothing is loaded in the cycle after a coast cycle
    a_r10_no_load_after_coast: assert property (@(posedge clk) disable iff (!rst_n)
        coast_req |=> !load_strobe);

    // R2: lock only rises after two cycles of a locked PLL
    a_r2_lock_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(audio_locked) |-> ($past(tmds_pll_locked) && $past(tmds_pll_locked, 2)));

    // R4: PLL loss drops lock in the next cycle
    a_r4_unlock_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !tmds_pll_locked |=> !audio_locked);

    // R7: masked PLL loss always requests coast
    a_r7_pll_loss_coasts: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_pll && !tmds_pll_locked) |-> coast_req);

    // R9: coast persists without a packet
    a_r9_coast_held: assert property (@(posedge clk) disable iff (!rst_n)
        (coast_req && !acr_valid) |=> coast_req);
endmodule

bind acr_lock_ctrl acr_lock_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .tmds_pll_locked(tmds_pll_locked), .acr_valid(acr_valid),
    .coast_req(coast_req), .load_strobe(load_strobe),
    .audio_locked(audio_locked), .mask_pll(coast_mask[5])
);

// File: tb/acr_lock_ctrl_test.sv
`timescale 1ns/1ps
module acr_lock_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acr_valid = 1'b0;
    logic [19:0] acr_n = '0, acr_cts = '0;
    logic        tmds_pll_locked = 1'b0;
    logic        ev_clk_irregular = 1'b0, ev_no_clk = 1'b0, ev_port_change = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        load_strobe, coast_req, audio_locked;
    logic [19:0] load_n, load_cts;

    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    acr_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .acr_valid(acr_valid), .acr_n(acr_n), .acr_cts(acr_cts),
        .tmds_pll_locked(tmds_pll_locked), .ev_clk_irregular(ev_clk_irregular),
        .ev_no_clk(ev_no_clk), .ev_port_change(ev_port_change),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .load_strobe(load_strobe), .load_n(load_n),
        .load_cts(load_cts), .coast_req(coast_req), .audio_locked(audio_locked)
    );

    // ---------------- behavioural reference model ----------------
    int m_lock_cnt, m_mask, m_thr;
    bit m_seen, m_have, m_pend, m_strobe, m_sticky, m_force;
    int m_lat_n, m_lat_c, m_ld_n, m_ld_c;

    function automatic bit m_good();
        return acr_valid && acr_n != 0 && acr_cts != 0;
    endfunction

    function automatic bit m_event();
        int d;
        bit e;
        d = int'(acr_cts) - m_lat_c;
        if (d < 0) d = -d;
        e = 0;
        if (m_good() && m_have && int'(acr_n) != m_lat_n && m_mask[2]) e = 1;
        if (m_good() && m_have && d > m_thr && m_mask[3]) e = 1;
        if (!tmds_pll_locked && m_mask[5]) e = 1;
        if (ev_clk_irregular && m_mask[6]) e = 1;
        if (ev_port_change && m_mask[1]) e = 1;
        if (ev_no_clk && m_mask[0]) e = 1;
        return e;
    endfunction

    function automatic int m_rdata();
        case (reg_addr)
            2'd1: return m_mask;
            2'd2: return m_thr;
            2'd3: return (m_lock_cnt == 2) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock_cnt = 0; m_mask = 0; m_thr = 0; m_seen = 0; m_have = 0;
            m_pend = 0; m_strobe = 0; m_sticky = 0; m_force = 0;
            m_lat_n = 0; m_lat_c = 0; m_ld_n = 0; m_ld_c = 0;
        end else begin
            bit g, ev, cst, want;
            g    = m_good();
            ev   = m_event();
            cst  = ev || m_sticky;
            want = m_pend || m_force ||
                   (g && (int'(acr_n) != m_ld_n || int'(acr_cts) != m_ld_c));
            if (want && !cst) begin
                m_strobe = 1; m_pend = 0;
                m_ld_n = g ? int'(acr_n) : m_lat_n;
                m_ld_c = g ? int'(acr_cts) : m_lat_c;
            end else begin
                m_strobe = 0; m_pend = want;
            end
            if (ev) m_sticky = 1; else if (g) m_sticky = 0;
            if (!tmds_pll_locked) begin m_lock_cnt = 0; m_seen = 0; end
            else if (m_seen || g) begin
                m_seen = 1;
                if (m_lock_cnt < 2) m_lock_cnt++;
            end
            if (g) begin m_lat_n = int'(acr_n); m_lat_c = int'(acr_cts); m_have = 1; end
            m_force = reg_wr_en && reg_addr == 2'd0 && reg_wdata[0];
            if (reg_wr_en && reg_addr == 2'd1) m_mask = int'(reg_wdata & 8'h6F);
            if (reg_wr_en && reg_addr == 2'd2) m_thr = int'(reg_wdata[5:0]);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 lock vs model", audio_locked, (m_lock_cnt == 2));
        chk("R5 strobe vs model", load_strobe, m_strobe);
        if (m_strobe) begin
            chk("R5 load_n vs model", load_n, m_ld_n);
            chk("R5 load_cts vs model", load_cts, m_ld_c);
        end
        chk("R9 coast vs model", coast_req, m_event() || m_sticky);
        chk("R11 rdata vs model", reg_rdata, m_rdata());
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic send_pkt(input int n, input int c);
        acr_valid = 1'b1; acr_n = 20'(n); acr_cts = 20'(c);
        step();
    endtask

    task automatic end_pkt();
        acr_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 lock", audio_locked, 0);
        chk("R1 strobe", load_strobe, 0);
        chk("R1 coast", coast_req, 0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a); #1;
            chk("R1 reg zero", reg_rdata, 0);
        end
        reg_addr = 2'd3;
        tmds_pll_locked = 1'b1;
        step();

        // R3 zero N ignored
        send_pkt(0, 25000); end_pkt();
        chk("R3 zero pkt no strobe", load_strobe, 0);
        step(); step();
        chk("R3 zero pkt no lock", audio_locked, 0);

        // R2 / R5 first good packet
        send_pkt(6144, 25000); end_pkt();
        chk("R5 strobe t+1", load_strobe, 1);
        chk("R5 load_n", load_n, 6144);
        chk("R2 not yet locked t+1", audio_locked, 0);
        step();
        chk("R2 locked t+2", audio_locked, 1);
        chk("R11 status bit", reg_rdata, 1);
        send_pkt(6144, 25000); end_pkt();
        chk("R5 same pair no strobe", load_strobe, 0);

        // R7 mask layout, R11 threshold
        wr_reg(2'd1, 8'hFF);
        reg_addr = 2'd1; #1;
        chk("R7 mask readback", reg_rdata, 8'h6F);
        wr_reg(2'd2, 8'd10);
        reg_addr = 2'd2; #1;
        chk("R11 thr readback", reg_rdata, 10);
        wr_reg(2'd3, 8'hFF);
        reg_addr = 2'd3; #1;
        chk("R11 status write ignored", reg_rdata, 1);

        // R8 threshold boundary
        send_pkt(6144, 25010); end_pkt();
        chk("R8 equal diff no coast strobe", load_strobe, 1);
        step();
        chk("R8 equal diff no coast", coast_req, 0);
        send_pkt(6144, 25021); end_pkt();
        chk("R8 diff above thr coast", coast_req, 1);
        chk("R10 no strobe in coast", load_strobe, 0);
        repeat (3) step();
        chk("R9 coast stretched", coast_req, 1);
        send_pkt(6144, 25021); end_pkt();
        chk("R9 coast drops after clean pkt", coast_req, 0);
        chk("R10 still held", load_strobe, 0);
        step();
        chk("R10 pending reload issued", load_strobe, 1);
        chk("R10 pending cts", load_cts, 25021);

        // N change
        send_pkt(6000, 25021); end_pkt();
        chk("R7 N change coast", coast_req, 1);
        step();
        send_pkt(6000, 25021); end_pkt();
        step();
        chk("R10 N reload after coast", load_n, 6000);

        // port change pulse
        ev_port_change = 1'b1; step(); ev_port_change = 1'b0;
        repeat (2) step();
        chk("R9 port pulse stretched", coast_req, 1);
        send_pkt(0, 5); end_pkt();
        chk("R3 invalid pkt keeps coast", coast_req, 1);
        send_pkt(6000, 25021); end_pkt();
        chk("R9 cleared", coast_req, 0);

        // no-clock with mask bit 0 cleared, then set
        wr_reg(2'd1, 8'h6E);
        ev_no_clk = 1'b1; step();
        chk("R7 unmasked no coast", coast_req, 0);
        wr_reg(2'd1, 8'h6F);
        chk("R7 masked no clk coast", coast_req, 1);
        ev_no_clk = 1'b0; step();
        ev_clk_irregular = 1'b1; step(); ev_clk_irregular = 1'b0; step();
        chk("R7 irregular clk coast", coast_req, 1);
        send_pkt(6000, 25021); end_pkt(); step();

        // R6 force update
        wr_reg(2'd0, 8'h01);
        chk("R6 not yet", load_strobe, 0);
        reg_addr = 2'd0; #1;
        chk("R6 reads zero", reg_rdata, 0);
        step();
        chk("R6 forced strobe", load_strobe, 1);
        chk("R6 forced n", load_n, 6000);
        wr_reg(2'd0, 8'h00);
        step();
        chk("R6 write zero no strobe", load_strobe, 0);

        // R4 PLL loss
        reg_addr = 2'd3;
        tmds_pll_locked = 1'b0; step();
        chk("R4 lock drops", audio_locked, 0);
        chk("R7 pll loss coast", coast_req, 1);
        tmds_pll_locked = 1'b1;
        repeat (4) step();
        chk("R4 needs new packet", audio_locked, 0);
        send_pkt(6000, 25021); end_pkt();
        step();
        chk("R4 relocked", audio_locked, 1);

        // force during coast is deferred
        ev_port_change = 1'b1; step(); ev_port_change = 1'b0;
        wr_reg(2'd0, 8'h01); step();
        chk("R10 force held in coast", load_strobe, 0);
        send_pkt(6000, 25021); end_pkt(); step();
        chk("R10 force released", load_strobe, 1);
        repeat (3) step();

        finish_run();
    end
endmodule